// File: doc/BRIEF.md
# CPU clock frequency-change sequencer

This block steps a processor core clock between sixteen operating levels. Level 0 is 1700 MHz, and each higher level is 100 MHz slower, down to 200 MHz at level 15. A one-cycle start strobe carries a target level. The sequencer compares the target against the level it currently holds and picks one of two procedures. When the PLL feedback and pre-divider settings of the two levels differ, it performs a full relock. Otherwise it rewrites only the post-divider setting.

A full relock first parks the core on a fixed alternate PLL through a glitch-free mux. The sequencer then loads the PLL lock count and writes the new configuration word. After the PLL reports lock, it returns the core to the main PLL. A separate divider-update unit is driven through a request/done handshake. The direction of the change fixes the order of the two steps. When the clock speeds up, the dividers are retuned first and the PLL second. When the clock slows down, the PLL changes first and the dividers follow.

Top module: `clkstep_seq`

## Requirements
- R1: After reset the current level is 0, the mux selects the main PLL, the lock count is 0, the configuration word holds the level-0 value, and busy, done and the divider request are low.
- R2: The configuration word carries M in bits 25:16, P in bits 13:8 and S in bits 2:0, with all other bits zero. The per-level M/P/S values are: 0:425/6/0, 1:200/3/0, 2:250/4/0, 3:175/3/0, 4:325/6/0, 5:200/4/0, 6:275/6/0, 7:125/3/0, 8:150/4/0, 9:100/3/0, 10:175/3/1, 11:200/4/1, 12:125/3/1, 13:100/3/1, 14:200/4/2, 15:100/3/2.
- R3: A start whose target equals the current level has no effect: busy stays low, no done pulse occurs, and all outputs are unchanged.
- R4: A full relock happens exactly when the target's M or P differs from the current level's. Otherwise only bits 2:0 of the word are rewritten, the mux is not touched and no lock wait occurs.
- R5: For a target below the current index (faster), the divider handshake completes before the PLL step begins. For a target above the current index (slower), the PLL step completes before the divider request is raised.
- R6: A relock sets the mux select to the alternate PLL (1) and waits for mux status code 2. In the cycle that status is seen, the lock count becomes target P × 250. The full target word is written in the following cycle, and no configuration change to M or P happens while the main PLL is selected.
- R7: After the word write, the sequencer waits for the lock flag and then selects the main PLL (0). The relock step ends in the cycle mux status code 1 is seen.
- R8: The divider request rises with the divider level output equal to the target level. It stays high, with that level stable, until the cycle in which divider done is sampled, and it is never high while idle.
- R9: Busy rises on the clock edge that accepts a start and falls on the edge that raises done. Done lasts one cycle, and the current level takes the target value on that same edge.
- R10: A start received while busy is ignored, including one present in the cycle that completes a change. A start held high is evaluated again from the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a level change |
| target_i | input | 4 | Requested level index |
| mux_stat_i | input | 3 | Core mux status (1 main, 2 alternate) |
| pll_locked_i | input | 1 | Main PLL lock flag |
| div_done_i | input | 1 | Divider-update unit finished |
| cur_level_o | output | 4 | Level currently applied |
| mux_sel_alt_o | output | 1 | Core mux select, 1 = alternate PLL |
| lock_cnt_o | output | 16 | PLL lock count value |
| pms_word_o | output | 32 | PLL configuration word |
| div_req_o | output | 1 | Request to the divider-update unit |
| div_level_o | output | 4 | Level the divider unit must apply |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion of one change and the acceptance of the next can fall in the same cycle. To provoke this, the bench holds start high through the finishing cycle, once with a target that differs from the old level and once with a target equal to the new level. It then moves the target while start is still held. A behavioural model judges the result: no second change may begin before the cycle after done, and the held same-level target must produce nothing. Environment latencies for mux status, lock and divider done are varied, including zero-cycle responses, so that each handshake is also sampled in its earliest possible cycle.

// File: rtl/clkstep_pkg.sv
package clkstep_pkg;

  localparam int WORD_W = 32;
  localparam int M_LSB  = 16;
  localparam int M_W    = 10;
  localparam int P_LSB  = 8;
  localparam int P_W    = 6;
  localparam int S_LSB  = 0;
  localparam int S_W    = 3;

  localparam logic [WORD_W-1:0] PM_MASK =
    (WORD_W'((1 << M_W) - 1) << M_LSB) | (WORD_W'((1 << P_W) - 1) << P_LSB);

  localparam logic [2:0] MUXST_MAIN = 3'd1;
  localparam logic [2:0] MUXST_ALT  = 3'd2;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_DIV_REQ,
    SQ_DIV_WAIT,
    SQ_S_ONLY,
    SQ_PARK,
    SQ_WAIT_ALT,
    SQ_WRITE,
    SQ_WAIT_LOCK,
    SQ_WAIT_MAIN,
    SQ_FINISH
  } seq_state_e;

  function automatic logic [WORD_W-1:0] make_word(input int m, input int p, input int s);
    return (WORD_W'(m) << M_LSB) | (WORD_W'(p) << P_LSB) | (WORD_W'(s) << S_LSB);
  endfunction

  // feedback / pre-divider / post-divider per level, fastest first
  function automatic logic [WORD_W-1:0] level_pms(input int lvl);
    case (lvl)
      0:       return make_word(425, 6, 0);
      1:       return make_word(200, 3, 0);
      2:       return make_word(250, 4, 0);
      3:       return make_word(175, 3, 0);
      4:       return make_word(325, 6, 0);
      5:       return make_word(200, 4, 0);
      6:       return make_word(275, 6, 0);
      7:       return make_word(125, 3, 0);
      8:       return make_word(150, 4, 0);
      9:       return make_word(100, 3, 0);
      10:      return make_word(175, 3, 1);
      11:      return make_word(200, 4, 1);
      12:      return make_word(125, 3, 1);
      13:      return make_word(100, 3, 1);
      14:      return make_word(200, 4, 2);
      default: return make_word(100, 3, 2);
    endcase
  endfunction

endpackage

// File: rtl/clkstep_pms_rom.sv
module clkstep_pms_rom
  import clkstep_pkg::*;
#(
  parameter int LEVELS   = 16,
  parameter int LVL_W    = $clog2(LEVELS),
  parameter int RD_PORTS = 3
) (
  input  logic [RD_PORTS-1:0][LVL_W-1:0]  idx_i,
  output logic [RD_PORTS-1:0][WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] table_w [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_entry
    assign table_w[g] = level_pms(g);
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_port
    assign word_o[r] = table_w[idx_i[r]];
  end

endmodule

// File: rtl/clkstep_plan.sv
module clkstep_plan
  import clkstep_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int LVL_W  = $clog2(LEVELS)
) (
  input  logic [LVL_W-1:0]  req_lvl_i,
  input  logic [LVL_W-1:0]  cur_lvl_i,
  input  logic [WORD_W-1:0] req_word_i,
  input  logic [WORD_W-1:0] cur_word_i,
  output logic              relock_o,
  output logic              faster_o
);

  // a relock is needed only when feedback or pre-divider settings move
  assign relock_o = |((req_word_i ^ cur_word_i) & PM_MASK);
  // lower index means a higher clock
  assign faster_o = (req_lvl_i < cur_lvl_i);

endmodule

// File: rtl/clkstep_fsm.sv
module clkstep_fsm
  import clkstep_pkg::*;
#(
  parameter int LEVELS     = 16,
  parameter int LVL_W      = $clog2(LEVELS),
  parameter int LOCK_W     = 16,
  parameter int LOCK_PER_P = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  target_i,
  input  logic              relock_i,
  input  logic              faster_i,
  input  logic [WORD_W-1:0] tgt_word_i,
  input  logic [2:0]        mux_stat_i,
  input  logic              pll_locked_i,
  input  logic              div_done_i,
  output logic [LVL_W-1:0]  cur_level_o,
  output logic [LVL_W-1:0]  tgt_level_o,
  output logic              mux_alt_o,
  output logic [LOCK_W-1:0] lock_cnt_o,
  output logic [WORD_W-1:0] pms_word_o,
  output logic              div_req_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e state_q;
  logic       relock_q;
  logic       faster_q;
  seq_state_e pll_entry;
  logic [LOCK_W-1:0] lock_val;

  assign pll_entry = relock_q ? SQ_PARK : SQ_S_ONLY;
  assign lock_val  = LOCK_W'(tgt_word_i[P_LSB +: P_W]) * LOCK_W'(LOCK_PER_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      relock_q    <= 1'b0;
      faster_q    <= 1'b0;
      cur_level_o <= '0;
      tgt_level_o <= '0;
      mux_alt_o   <= 1'b0;
      lock_cnt_o  <= '0;
      pms_word_o  <= level_pms(0);
      div_req_o   <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i && (target_i != cur_level_o)) begin
            tgt_level_o <= target_i;
            relock_q    <= relock_i;
            faster_q    <= faster_i;
            busy_o      <= 1'b1;
            if (faster_i)      state_q <= SQ_DIV_REQ;
            else if (relock_i) state_q <= SQ_PARK;
            else               state_q <= SQ_S_ONLY;
          end
        end
        SQ_DIV_REQ: begin
          div_req_o <= 1'b1;
          state_q   <= SQ_DIV_WAIT;
        end
        SQ_DIV_WAIT: begin
          if (div_done_i) begin
            div_req_o <= 1'b0;
            state_q   <= faster_q ? pll_entry : SQ_FINISH;
          end
        end
        SQ_S_ONLY: begin
          pms_word_o[S_LSB +: S_W] <= tgt_word_i[S_LSB +: S_W];
          state_q <= faster_q ? SQ_FINISH : SQ_DIV_REQ;
        end
        SQ_PARK: begin
          mux_alt_o <= 1'b1;
          state_q   <= SQ_WAIT_ALT;
        end
        SQ_WAIT_ALT: begin
          if (mux_stat_i == MUXST_ALT) begin
            lock_cnt_o <= lock_val;
            state_q    <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          pms_word_o <= tgt_word_i;
          state_q    <= SQ_WAIT_LOCK;
        end
        SQ_WAIT_LOCK: begin
          if (pll_locked_i) begin
            mux_alt_o <= 1'b0;
            state_q   <= SQ_WAIT_MAIN;
          end
        end
        SQ_WAIT_MAIN: begin
          if (mux_stat_i == MUXST_MAIN) begin
            state_q <= faster_q ? SQ_FINISH : SQ_DIV_REQ;
          end
        end
        SQ_FINISH: begin
          cur_level_o <= tgt_level_o;
          busy_o      <= 1'b0;
          done_o      <= 1'b1;
          state_q     <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkstep_seq.sv
module clkstep_seq
  import clkstep_pkg::*;
#(
  parameter int LEVELS     = 16,
  parameter int LVL_W      = $clog2(LEVELS),
  parameter int LOCK_W     = 16,
  parameter int LOCK_PER_P = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  target_i,
  input  logic [2:0]        mux_stat_i,
  input  logic              pll_locked_i,
  input  logic              div_done_i,
  output logic [LVL_W-1:0]  cur_level_o,
  output logic              mux_sel_alt_o,
  output logic [LOCK_W-1:0] lock_cnt_o,
  output logic [WORD_W-1:0] pms_word_o,
  output logic              div_req_o,
  output logic [LVL_W-1:0]  div_level_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int RD_PORTS = 3;

  logic [RD_PORTS-1:0][LVL_W-1:0]  rom_idx;
  logic [RD_PORTS-1:0][WORD_W-1:0] rom_word;
  logic [LVL_W-1:0]                tgt_lvl;
  logic                            relock;
  logic                            faster;

  // port 0: requested level, port 1: current level, port 2: latched target
  assign rom_idx = {tgt_lvl, cur_level_o, target_i};

  clkstep_pms_rom #(
    .LEVELS   (LEVELS),
    .LVL_W    (LVL_W),
    .RD_PORTS (RD_PORTS)
  ) u_rom (
    .idx_i  (rom_idx),
    .word_o (rom_word)
  );

  clkstep_plan #(
    .LEVELS (LEVELS),
    .LVL_W  (LVL_W)
  ) u_plan (
    .req_lvl_i  (target_i),
    .cur_lvl_i  (cur_level_o),
    .req_word_i (rom_word[0]),
    .cur_word_i (rom_word[1]),
    .relock_o   (relock),
    .faster_o   (faster)
  );

  clkstep_fsm #(
    .LEVELS     (LEVELS),
    .LVL_W      (LVL_W),
    .LOCK_W     (LOCK_W),
    .LOCK_PER_P (LOCK_PER_P)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .target_i     (target_i),
    .relock_i     (relock),
    .faster_i     (faster),
    .tgt_word_i   (rom_word[2]),
    .mux_stat_i   (mux_stat_i),
    .pll_locked_i (pll_locked_i),
    .div_done_i   (div_done_i),
    .cur_level_o  (cur_level_o),
    .tgt_level_o  (tgt_lvl),
    .mux_alt_o    (mux_sel_alt_o),
    .lock_cnt_o   (lock_cnt_o),
    .pms_word_o   (pms_word_o),
    .div_req_o    (div_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  assign div_level_o = tgt_lvl;

endmodule

// File: rtl/clkstep_seq_chk.sv
module clkstep_seq_chk #(
  parameter int LVL_W  = 4,
  parameter int LOCK_W = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic [LVL_W-1:0]  cur_level_o,
  input logic              div_req_o,
  input logic              div_done_i,
  input logic [LVL_W-1:0]  div_level_o,
  input logic              mux_sel_alt_o,
  input logic [LOCK_W-1:0] lock_cnt_o,
  input logic [WORD_W-1:0] pms_word_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R9

  AST_LEVEL_MOVES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(cur_level_o) || done_o)); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (div_req_o && !div_done_i) |=> div_req_o); // R8

  AST_REQ_LEVEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    div_req_o |=> (!div_req_o || $stable(div_level_o))); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !div_req_o); // R8

  AST_IDLE_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mux_sel_alt_o); // R7

  AST_PM_ONLY_PARKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(pms_word_o[25:8]) || mux_sel_alt_o)); // R6

  AST_LOCK_ONLY_PARKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(lock_cnt_o) || mux_sel_alt_o)); // R6

endmodule

bind clkstep_seq clkstep_seq_chk #(
  .LVL_W  (LVL_W),
  .LOCK_W (LOCK_W),
  .WORD_W (clkstep_pkg::WORD_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .cur_level_o   (cur_level_o),
  .div_req_o     (div_req_o),
  .div_done_i    (div_done_i),
  .div_level_o   (div_level_o),
  .mux_sel_alt_o (mux_sel_alt_o),
  .lock_cnt_o    (lock_cnt_o),
  .pms_word_o    (pms_word_o)
);

// File: tb/clkstep_seq_tb.sv
module clkstep_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [3:0]  target_i = '0;
  logic [2:0]  mux_stat_i = 3'd1;
  logic        pll_locked_i = 1'b1;
  logic        div_done_i = 1'b0;
  logic [3:0]  cur_level_o;
  logic        mux_sel_alt_o;
  logic [15:0] lock_cnt_o;
  logic [31:0] pms_word_o;
  logic        div_req_o;
  logic [3:0]  div_level_o;
  logic        busy_o;
  logic        done_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clkstep_seq u_dut (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .target_i      (target_i),
    .mux_stat_i    (mux_stat_i),
    .pll_locked_i  (pll_locked_i),
    .div_done_i    (div_done_i),
    .cur_level_o   (cur_level_o),
    .mux_sel_alt_o (mux_sel_alt_o),
    .lock_cnt_o    (lock_cnt_o),
    .pms_word_o    (pms_word_o),
    .div_req_o     (div_req_o),
    .div_level_o   (div_level_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // level table as given in R2
  function automatic logic [31:0] bench_word(input int lvl);
    int m, p, s;
    case (lvl)
      0:  begin m = 425; p = 6; s = 0; end
      1:  begin m = 200; p = 3; s = 0; end
      2:  begin m = 250; p = 4; s = 0; end
      3:  begin m = 175; p = 3; s = 0; end
      4:  begin m = 325; p = 6; s = 0; end
      5:  begin m = 200; p = 4; s = 0; end
      6:  begin m = 275; p = 6; s = 0; end
      7:  begin m = 125; p = 3; s = 0; end
      8:  begin m = 150; p = 4; s = 0; end
      9:  begin m = 100; p = 3; s = 0; end
      10: begin m = 175; p = 3; s = 1; end
      11: begin m = 200; p = 4; s = 1; end
      12: begin m = 125; p = 3; s = 1; end
      13: begin m = 100; p = 3; s = 1; end
      14: begin m = 200; p = 4; s = 2; end
      default: begin m = 100; p = 3; s = 2; end
    endcase
    return (32'(m) << 16) | (32'(p) << 8) | 32'(s);
  endfunction

  // ---------------- environment ----------------
  int mux_lat = 2, lock_lat = 3, div_lat = 2;
  logic m_seen = 1'b0;
  int   m_cnt = 0;
  logic [17:0] l_seen;
  int   l_cnt = 0;
  int   d_cnt = 0;

  initial l_seen = bench_word(0)>>8;

  always @(negedge clk) begin
    if (mux_sel_alt_o !== m_seen && !$isunknown(mux_sel_alt_o)) begin
      m_seen = mux_sel_alt_o;
      m_cnt  = mux_lat;
      mux_stat_i = (mux_lat == 0) ? (m_seen ? 3'd2 : 3'd1) : 3'd0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) mux_stat_i = m_seen ? 3'd2 : 3'd1;
    end
    if (!$isunknown(pms_word_o) && pms_word_o[25:8] != l_seen) begin
      l_seen = pms_word_o[25:8];
      if (lock_lat > 0) begin
        pll_locked_i = 1'b0;
        l_cnt = lock_lat;
      end
    end else if (l_cnt > 0) begin
      l_cnt--;
      if (l_cnt == 0) pll_locked_i = 1'b1;
    end
    if (div_req_o === 1'b1 && !div_done_i) begin
      if (d_cnt >= div_lat) begin
        div_done_i = 1'b1;
        d_cnt = 0;
      end else d_cnt++;
    end else begin
      div_done_i = 1'b0;
      d_cnt = 0;
    end
  end

  // ---------------- behavioural reference ----------------
  int          e_cur = 0, e_tgt = 0;
  bit          e_alt = 0, e_req = 0, e_busy = 0, e_done = 0;
  logic [15:0] e_lock = '0;
  logic [31:0] e_pms;

  initial e_pms = bench_word(0);

  task automatic model_div();
    @(posedge clk);
    e_req = 1;
    do @(posedge clk); while (!div_done_i);
    e_req = 0;
  endtask

  task automatic model_pll(input int t, input bit relock);
    logic [31:0] w;
    w = bench_word(t);
    if (!relock) begin
      @(posedge clk);
      e_pms[2:0] = w[2:0];
    end else begin
      @(posedge clk);
      e_alt = 1;
      do @(posedge clk); while (mux_stat_i != 3'd2);
      e_lock = 16'(w[13:8]) * 16'd250;
      @(posedge clk);
      e_pms = w;
      do @(posedge clk); while (!pll_locked_i);
      e_alt = 0;
      do @(posedge clk); while (mux_stat_i != 3'd1);
    end
  endtask

  task automatic model_change(input int t);
    bit fast, relock;
    e_busy = 1;
    e_tgt  = t;
    fast   = (t < e_cur);
    relock = (bench_word(t) >> 8) != (bench_word(e_cur) >> 8);
    if (fast) begin
      model_div();
      model_pll(t, relock);
    end else begin
      model_pll(t, relock);
      model_div();
    end
    @(posedge clk);
    e_cur  = t;
    e_busy = 0;
    e_done = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      e_done = 0;
      if (!rst && !e_busy && start_i && int'(target_i) != e_cur)
        model_change(int'(target_i));
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9", "cur_level", cur_level_o, e_cur);
      chk("R9", "busy", busy_o, e_busy);
      chk("R9", "done", done_o, e_done);
      chk("R6", "mux_sel_alt", mux_sel_alt_o, e_alt);
      chk("R6", "lock_cnt", lock_cnt_o, e_lock);
      chk("R2", "pms_word", pms_word_o, e_pms);
      chk("R8", "div_req", div_req_o, e_req);
      chk("R8", "div_level", div_level_o, e_tgt);
    end
  end

  // ---------------- ordering and path monitor ----------------
  int cyc = 0, t_req = -1, t_pms = -1, from_lvl = 0;
  bit seen_alt = 0, prev_busy = 0;
  logic [31:0] prev_pms;

  always @(negedge clk) begin
    cyc++;
    if (!rst && !finished) begin
      if (busy_o && !prev_busy) begin
        t_req = -1; t_pms = -1; seen_alt = 0;
        from_lvl = int'(cur_level_o);
      end
      if (div_req_o && t_req < 0) t_req = cyc;
      if (pms_word_o != prev_pms && t_pms < 0 && busy_o) t_pms = cyc;
      if (mux_sel_alt_o) seen_alt = 1;
      if (done_o) begin
        // R5: order of divider and PLL steps follows the direction
        if (int'(cur_level_o) < from_lvl) chk("R5", "div before pll", t_req < t_pms, 1);
        else                              chk("R5", "pll before div", t_pms < t_req, 1);
        // R4: relock only when M or P move
        chk("R4", "relock path", seen_alt,
            (bench_word(int'(cur_level_o)) >> 8) != (bench_word(from_lvl) >> 8));
      end
    end
    prev_busy = busy_o;
    prev_pms  = pms_word_o;
  end

  // ---------------- stimulus ----------------
  task automatic set_env(input int m, input int l, input int d);
    mux_lat = m; lock_lat = l; div_lat = d;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic change(input int t);
    @(negedge clk);
    start_i = 1; target_i = 4'(t);
    @(negedge clk);
    start_i = 0;
    wait_idle();
    chk("R9", "level after change", cur_level_o, t);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset level", cur_level_o, 0);
    chk("R1", "reset mux", mux_sel_alt_o, 0);
    chk("R1", "reset lock", lock_cnt_o, 0);
    chk("R1", "reset word", pms_word_o, 32'h01A9_0600);
    chk("R1", "reset busy/done/req", {busy_o, done_o, div_req_o}, 0);

    // R3: same-level request
    @(negedge clk); start_i = 1; target_i = 4'd0;
    @(negedge clk); start_i = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R3", "busy on same level", busy_o, 0);
      chk("R3", "done on same level", done_o, 0);
    end

    set_env(2, 3, 2); change(9);   // slower, relock
    set_env(1, 1, 0); change(13);  // slower, S only
    set_env(0, 0, 0); change(9);   // faster, S only
    set_env(0, 0, 1); change(7);   // faster, relock, zero-latency mux/lock
    set_env(3, 5, 4); change(12);  // slower, S only
    set_env(1, 2, 1); change(15);  // slower, relock
    set_env(2, 0, 3); change(13);  // faster, S only
    set_env(4, 6, 2); change(0);   // faster, relock, max lock count
    chk("R6", "lock count for level 0", lock_cnt_o, 6 * 250);

    // R10: start while busy is dropped
    set_env(2, 3, 2);
    @(negedge clk); start_i = 1; target_i = 4'd5;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    start_i = 1; target_i = 4'd3;
    @(negedge clk); start_i = 0;
    wait_idle();
    chk("R10", "level after busy start", cur_level_o, 5);

    // R10: held start across the finishing cycle
    @(negedge clk); start_i = 1; target_i = 4'd11;
    @(negedge clk);
    while (!done_o) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk("R10", "held same-level start", busy_o, 0);
    end
    chk("R10", "level after held start", cur_level_o, 11);
    target_i = 4'd4;
    @(negedge clk);
    chk("R10", "held start re-evaluated", busy_o, 1);
    start_i = 0;
    wait_idle();
    chk("R10", "level after second change", cur_level_o, 4);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual busy %0d expected 0", busy_o);
      summary();
      $finish;
    end
  end

endmodule